// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block produces the processor side of an external memory bus cycle in which the low address byte and the data byte share a single set of eight lines, one after the other. A fast reference clock drives an internal phase counter. From that counter the block derives a bus clock that runs at one quarter of the reference rate. Each bus clock period is one bus cycle. The first half, with the bus clock low, carries the address. The second half, with the bus clock high, carries data. The upper address byte has its own dedicated lines and holds for the whole cycle. An address strobe pulses at the start of each cycle, so an external latch can capture the low byte on the strobe's falling edge.

Transactions come in on a valid/ready handshake. A request holds its address, write data and direction stable until ready pulses. The block takes a request only at a cycle boundary. On reads, it samples the shared lines on the last reference tick before the bus clock falls and returns that byte with the ready pulse. When no request has been taken, the block runs idle read cycles at address zero, so the bus clock never stops.

Top module: `mbus_cycle_gen`

## Requirements
- R1: A bus cycle lasts 4 reference ticks (2*HALF). `bus_e` is low in ticks 0 and 1 and high in ticks 2 and 3, so it toggles without pause.
- R2: `bus_as` is high in tick 0 of every cycle only, while `bus_e` is low. It falls at the start of tick 1.
- R3: `bus_addr_hi` carries bits 15..8 of the cycle's address and holds one value for all four ticks of a cycle.
- R4: While `bus_e` is low, `bus_ad_oe` is 1 and `bus_ad_out` carries bits 7..0 of the cycle's address.
- R5: While `bus_e` is high, a write cycle drives `bus_ad_out` with the write data and `bus_ad_oe`=1. A read cycle releases the lines (`bus_ad_oe`=0).
- R6: `bus_rw` is set in tick 0 and holds for the whole cycle. 1 means read and 0 means write.
- R7: For a read transaction, `rsp_rdata` equals the value on `bus_ad_in` during tick 3 of that cycle, the last tick before `bus_e` falls. It is valid while `req_ready` is high.
- R8: `req_ready` is a one-tick pulse in tick 0 of the cycle that follows each transaction cycle. It never goes high at any other time.
- R9: A request is taken only at the end of tick 3, when a transaction is not in flight. A request that arrives in the middle of a cycle does not change that cycle. The cycle after a transaction cycle is always idle.
- R10: Idle cycles are reads at address 0 (`bus_rw`=1, `bus_addr_hi`=0, `bus_ad_out`=0 in the address phase).
- R11: During and right after synchronous reset, the pins show tick 0 of an idle cycle: `bus_e`=0, `bus_as`=1, `bus_rw`=1, address 0, `bus_ad_oe`=1, `req_ready`=0, `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| bus_ad_in | input | 8 | Value seen on the shared address/data lines |
| req_ready | output | 1 | One-tick completion pulse |
| rsp_rdata | output | 8 | Read data, valid with req_ready |
| bus_e | output | 1 | Bus clock, quarter of reference |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr_hi | output | 8 | Upper address byte |
| bus_ad_out | output | 8 | Shared lines, value driven |
| bus_ad_oe | output | 1 | Shared lines driven when 1 |

## Verification
Two events fall on the same reference edge: the end of tick 3 of a transaction cycle and the handover to the next cycle. On that edge the read byte is sampled, completion is scheduled, and a request could be taken. The requester still holds valid at that moment, because ready has not yet come. The bench provokes this with back-to-back random requests that appear in any tick. It judges the result by checking that the following cycle is idle at address 0 and that the captured byte is the tick-3 value. `bus_ad_in` gets a fresh random value every tick, so a sample taken one tick early or late shows up as a mismatch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned DEF_ADDR_W = 16;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_HALF   = 2;

  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;
endpackage

// File: rtl/mbus_phase.sv
module mbus_phase #(
  parameter int unsigned HALF = mbus_pkg::DEF_HALF,
  localparam int unsigned TICKS = 2 * HALF,
  localparam int unsigned PH_W = (TICKS > 2) ? $clog2(TICKS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph_q,
  output logic [PH_W-1:0] ph_d,
  output logic            wrap
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(TICKS - 1);

  assign wrap = (ph_q == LAST_PH);
  assign ph_d = wrap ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_d;
  end
endmodule

// File: rtl/mbus_sequencer.sv
module mbus_sequencer #(
  parameter int unsigned ADDR_W = mbus_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = mbus_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic [DATA_W-1:0] ad_in,
  output logic              cur_write_d,
  output logic [ADDR_W-1:0] cur_addr_d,
  output logic [DATA_W-1:0] cur_wdata_d,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              busy_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              busy_d;
  logic              take;

  // a transaction cycle is always followed by an idle one
  assign take = wrap && req_valid && !busy_q;

  always_comb begin
    busy_d      = busy_q;
    cur_write_d = write_q;
    cur_addr_d  = addr_q;
    cur_wdata_d = wdata_q;
    if (wrap) begin
      busy_d      = take;
      cur_write_d = take && req_write;
      cur_addr_d  = take ? req_addr  : '0;
      cur_wdata_d = take ? req_wdata : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      write_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      req_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      busy_q    <= busy_d;
      write_q   <= cur_write_d;
      addr_q    <= cur_addr_d;
      wdata_q   <= cur_wdata_d;
      req_ready <= wrap && busy_q;
      if (wrap && busy_q && !write_q)
        rsp_rdata <= ad_in;
    end
  end
endmodule

// File: rtl/mbus_pins.sv
module mbus_pins #(
  parameter int unsigned ADDR_W = mbus_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = mbus_pkg::DEF_DATA_W,
  parameter int unsigned HALF   = mbus_pkg::DEF_HALF,
  localparam int unsigned TICKS = 2 * HALF,
  localparam int unsigned PH_W = (TICKS > 2) ? $clog2(TICKS) : 1,
  localparam int unsigned HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph_d,
  input  logic              write_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [DATA_W-1:0] wdata_d,
  output logic              bus_e,
  output logic              bus_as,
  output logic              bus_rw,
  output logic [HI_W-1:0]   bus_addr_hi,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe
);
  import mbus_pkg::*;
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(HALF);

  logic e_d;
  assign e_d = (ph_d >= HALF_PH);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_e       <= 1'b0;
      bus_as      <= 1'b1;
      bus_rw      <= DIR_READ;
      bus_addr_hi <= '0;
      bus_ad_out  <= '0;
      bus_ad_oe   <= 1'b1;
    end else begin
      bus_e       <= e_d;
      bus_as      <= (ph_d == '0);
      bus_rw      <= write_d ? DIR_WRITE : DIR_READ;
      bus_addr_hi <= addr_d[ADDR_W-1:DATA_W];
      bus_ad_out  <= e_d ? wdata_d : addr_d[DATA_W-1:0];
      bus_ad_oe   <= !e_d || write_d;
    end
  end
endmodule

// File: rtl/mbus_cycle_gen.sv
module mbus_cycle_gen #(
  parameter int unsigned ADDR_W = mbus_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = mbus_pkg::DEF_DATA_W,
  parameter int unsigned HALF   = mbus_pkg::DEF_HALF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        bus_ad_in,
  output logic                     req_ready,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     bus_e,
  output logic                     bus_as,
  output logic                     bus_rw,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  output logic [DATA_W-1:0]        bus_ad_out,
  output logic                     bus_ad_oe
);
  localparam int unsigned TICKS = 2 * HALF;
  localparam int unsigned PH_W  = (TICKS > 2) ? $clog2(TICKS) : 1;

  logic [PH_W-1:0]   ph_q;
  logic [PH_W-1:0]   ph_d;
  logic              wrap;
  logic              cur_write_d;
  logic [ADDR_W-1:0] cur_addr_d;
  logic [DATA_W-1:0] cur_wdata_d;

  mbus_phase #(.HALF(HALF)) u_phase (
    .clk(clk), .rst(rst), .ph_q(ph_q), .ph_d(ph_d), .wrap(wrap)
  );

  mbus_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .wrap(wrap),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .ad_in(bus_ad_in),
    .cur_write_d(cur_write_d), .cur_addr_d(cur_addr_d),
    .cur_wdata_d(cur_wdata_d),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata)
  );

  mbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF(HALF)) u_pins (
    .clk(clk), .rst(rst), .ph_d(ph_d),
    .write_d(cur_write_d), .addr_d(cur_addr_d), .wdata_d(cur_wdata_d),
    .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
    .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe)
  );

  logic unused_ph;
  assign unused_ph = ^ph_q;
endmodule

// File: rtl/mbus_cycle_gen_sva.sv
module mbus_cycle_gen_sva #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HALF   = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_e,
  input logic                     bus_as,
  input logic                     bus_rw,
  input logic [ADDR_W-DATA_W-1:0] bus_addr_hi,
  input logic                     bus_ad_oe,
  input logic                     req_ready
);
  logic [15:0] since_as;

  always_ff @(posedge clk) begin
    if (rst)         since_as <= '0;
    else if (bus_as) since_as <= 16'd1;
    else             since_as <= since_as + 16'd1;
  end

  AST_E_PHASE: assert property (@(posedge clk) disable iff (rst)
    !bus_as |-> (bus_e == (32'(since_as) >= HALF))); // R1
  AST_AS_RECURS: assert property (@(posedge clk) disable iff (rst)
    !bus_as |-> (32'(since_as) < 2 * HALF)); // R2
  AST_AS_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    bus_as |=> !bus_as); // R2
  AST_AS_E_LOW: assert property (@(posedge clk) disable iff (rst)
    bus_as |-> !bus_e); // R2
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_as |-> $stable(bus_addr_hi)); // R3
  AST_LO_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !bus_e |-> bus_ad_oe); // R4
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (bus_e && bus_rw) |-> !bus_ad_oe); // R5
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_e && !bus_rw) |-> bus_ad_oe); // R5
  AST_RW_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bus_as |-> $stable(bus_rw)); // R6
  AST_READY_TICK0: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_as); // R8
endmodule

bind mbus_cycle_gen mbus_cycle_gen_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF(HALF)
) u_sva (
  .clk(clk), .rst(rst), .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
  .bus_addr_hi(bus_addr_hi), .bus_ad_oe(bus_ad_oe), .req_ready(req_ready)
);

// File: tb/mbus_cycle_gen_test.sv
module mbus_cycle_gen_test;
  localparam int HALF   = 2;
  localparam int TICKS  = 2 * HALF;
  localparam int N_TXN  = 300;
  localparam int MAX_TK = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic [7:0]  bus_ad_in = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic        bus_e, bus_as, bus_rw, bus_ad_oe;
  logic [7:0]  bus_addr_hi, bus_ad_out;

  always #4 clk = ~clk;

  mbus_cycle_gen uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .bus_ad_in(bus_ad_in),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .bus_e(bus_e),
    .bus_as(bus_as), .bus_rw(bus_rw), .bus_addr_hi(bus_addr_hi),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // model of the cycle in progress
  int          ph = 0;
  logic        m_busy = 0, m_write = 0, m_ready = 0, m_rd_done = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;

  function automatic logic [15:0] pick_addr(input int idx);
    case (idx)
      0: return 16'hFFFF;
      1: return 16'h0000;
      2: return 16'h00FF;
      3: return 16'hFF00;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic new_req(input int idx);
    req_valid = 1'b1;
    req_addr  = pick_addr(idx);
    req_write = (idx < 4) ? (idx % 2 == 0) : 1'($urandom);
    req_wdata = (idx == 0) ? 8'hA5 : (idx == 2) ? 8'h00 : 8'($urandom);
  endtask

  initial begin
    int unsigned seed_set;
    int done = 0;
    int issued = 0;
    int tick = 0;
    seed_set = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "e", 16'(bus_e), 16'h0);
    chk("R11", "as", 16'(bus_as), 16'h1);
    chk("R11", "rw", 16'(bus_rw), 16'h1);
    chk("R11", "addr_hi", 16'(bus_addr_hi), 16'h0);
    chk("R11", "oe", 16'(bus_ad_oe), 16'h1);
    chk("R11", "ready", 16'(req_ready), 16'h0);
    chk("R11", "rdata", 16'(rsp_rdata), 16'h0);
    rst = 1'b0;
    while (done < N_TXN && tick < MAX_TK) begin
      logic take;
      // compare the current tick against the model
      chk("R1", "e", 16'(bus_e), 16'(ph >= HALF));
      chk("R2", "as", 16'(bus_as), 16'(ph == 0));
      chk("R6", "rw", 16'(bus_rw), 16'(!m_write));
      chk(m_busy ? "R3" : "R10", "addr_hi", 16'(bus_addr_hi), 16'(m_addr[15:8]));
      if (ph < HALF) begin
        chk("R4", "oe", 16'(bus_ad_oe), 16'h1);
        chk(m_busy ? "R4" : "R10", "ad_lo", 16'(bus_ad_out), 16'(m_addr[7:0]));
      end else begin
        chk("R5", "oe", 16'(bus_ad_oe), 16'(m_write));
        if (m_write) chk("R5", "wdata", 16'(bus_ad_out), 16'(m_wdata));
      end
      chk("R8", "ready", 16'(req_ready), 16'(m_ready));
      if (m_ready && m_rd_done)
        chk("R7", "rdata", 16'(rsp_rdata), 16'(m_rdata));
      // requester: completion, then maybe a new request
      if (m_ready) begin
        done++;
        req_valid = 1'b0;
      end
      if (!req_valid && ($urandom_range(0, 2) == 0 || issued < 4)) begin
        new_req(issued);
        issued++;
      end
      bus_ad_in = 8'($urandom);
      // model the next tick, R9 boundary acceptance
      m_ready = (ph == TICKS - 1) && m_busy;
      if (ph == TICKS - 1) begin
        m_rd_done = m_busy && !m_write;
        if (m_busy && !m_write) m_rdata = bus_ad_in;
        take = req_valid && !m_busy;
        m_busy  = take;
        m_write = take && req_write;
        m_addr  = take ? req_addr : 16'h0;
        m_wdata = take ? req_wdata : 8'h0;
      end
      ph = (ph + 1) % TICKS;
      tick++;
      @(negedge clk);
    end
    if (done < N_TXN) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual %0d expected %0d completions", done, N_TXN);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule